// File: doc/BRIEF.md
# Dual-Hit Row Scanner

This block takes the per-channel current-difference samples of a pixel row readout, one channel per accepted transfer, and compares each sample with a programmable threshold. It stores the sample and its hit flag together in a row buffer that holds several rows. A scanner works on the oldest complete row. In each clock cycle it picks the two lowest-numbered channels that still have a set flag. It presents their channel numbers and sample values on two output ports, A and B. It also writes one record holding both hit addresses and the row number into a hit memory.

A row with no hits left is retired in one cycle. Retiring a row writes an end-of-row record. Rows are numbered from zero after reset, and channels are numbered from zero within each row. When the hit memory is full, further records are dropped and a sticky overflow flag is raised. The ports keep delivering hits while this happens. The hit memory is read through a plain synchronous read port, and a fill count is provided.

Top module: `dual_hit_scanner`

## Requirements
- R1: After reset, in_ready is 1, a_valid and b_valid are 0, hr_count is 0 and hr_overflow is 0.
- R2: An accepted sample is a hit when its unsigned value is greater than or equal to the threshold, so equality counts as a hit. The threshold resets to all ones. A write through thr_we applies to samples accepted in later cycles.
- R3: In each output cycle, a_chan is the lowest pending hit channel of the row and b_chan is the next pending one. When only one hit remains, b_valid is 0. b_valid is never 1 without a_valid.
- R4: a_value and b_value carry the stored sample value of the channel shown beside them.
- R5: A row with no hits produces no port output and exactly one end-of-row record.
- R6: Each output cycle writes one hit record at the next sequential address, starting from 0. The record layout is: bits [6:0] A channel, bit 7 A valid, bits [14:8] B channel (zero when B is invalid), bit 15 B valid, bits [23:16] row, bit 24 end-of-row. These are the default positions.
- R7: After the last hit record of a row, an end-of-row record is written. It has bit 24 set, the row number in bits [23:16], and zeros in bits [15:0].
- R8: When hr_count equals HIT_DEPTH, records are dropped, hr_count stays at HIT_DEPTH and hr_overflow becomes 1 and stays 1. The ports still deliver all hits.
- R9: hr_data shows the record at hr_addr one clock after hr_addr is applied.
- R10: Samples are accepted on in_valid and in_ready. The channel number counts from 0 to CHANNELS-1 within a row, and the row number (out_row) increments per completed row starting at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_we | input | 1 | Threshold write strobe |
| thr_data | input | VAL_W | New threshold value |
| in_valid | input | 1 | Sample transfer valid |
| in_value | input | VAL_W | Current-difference sample |
| in_ready | output | 1 | Row buffer can accept a sample |
| a_valid | output | 1 | Port A carries a hit |
| a_chan | output | CH_W | Port A channel |
| a_value | output | VAL_W | Port A sample value |
| b_valid | output | 1 | Port B carries a hit |
| b_chan | output | CH_W | Port B channel |
| b_value | output | VAL_W | Port B sample value |
| out_row | output | ROW_W | Row number of the port hits |
| hr_addr | input | HIT_AW | Hit memory read address |
| hr_data | output | HIT_W | Hit memory read data |
| hr_count | output | HIT_AW+1 | Records stored |
| hr_overflow | output | 1 | Sticky record-drop flag |

## Verification
Two things can fall in the same cycle: a dual-hit output pair and the hit memory reaching its capacity. The bench provokes this by sending a row in which every channel is a hit, after the memory has already been partly filled. Every pair must still arrive on ports A and B in channel order with its values, as the scoreboard checks. At the same time, the count must stop at the depth, the overflow flag must be set, and the stored records up to the limit must match the expected stream when read back.

// File: rtl/dhs_pkg.sv
package dhs_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_HITS = 2'd1,
    ACT_EOR  = 2'd2
  } scan_act_e;
endpackage

// File: rtl/dhs_pick2.sv
// Finds the lowest and second-lowest set bits of a mask.
module dhs_pick2 #(
  parameter int N  = 128,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask,
  output logic          a_found,
  output logic [IW-1:0] a_idx,
  output logic          b_found,
  output logic [IW-1:0] b_idx
);
  logic [N-1:0] rest;

  always_comb begin
    a_found = 1'b0;
    a_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) begin
        a_found = 1'b1;
        a_idx   = IW'(i);
      end
    end
    rest = mask;
    if (a_found) rest[a_idx] = 1'b0;
    b_found = 1'b0;
    b_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (rest[i]) begin
        b_found = 1'b1;
        b_idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dhs_value_ram.sv
// One write port, one registered read port.
module dhs_value_ram #(
  parameter int W     = 12,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dhs_hit_ram.sv
// Append-only record store with fill count and sticky overflow.
module dhs_hit_ram #(
  parameter int W     = 25,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata,
  output logic [AW:0]   count,
  output logic          overflow
);
  localparam logic [AW:0] FULL = (AW + 1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic         room;

  assign room = (count != FULL);

  always_ff @(posedge clk) begin
    if (we && room) mem[count[AW-1:0]] <= wdata;
    rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      overflow <= 1'b0;
    end else if (we) begin
      if (room) count    <= count + 1'b1;
      else      overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/dual_hit_scanner.sv
module dual_hit_scanner
  import dhs_pkg::*;
#(
  parameter int CHANNELS  = 128,
  parameter int VAL_W     = 12,
  parameter int ROW_W     = 8,
  parameter int SLOTS     = 2,
  parameter int HIT_DEPTH = 64,
  localparam int CH_W     = $clog2(CHANNELS),
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int HIT_AW   = $clog2(HIT_DEPTH),
  localparam int HIT_W    = 2 * (CH_W + 1) + ROW_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              thr_we,
  input  logic [VAL_W-1:0]  thr_data,
  input  logic              in_valid,
  input  logic [VAL_W-1:0]  in_value,
  output logic              in_ready,
  output logic              a_valid,
  output logic [CH_W-1:0]   a_chan,
  output logic [VAL_W-1:0]  a_value,
  output logic              b_valid,
  output logic [CH_W-1:0]   b_chan,
  output logic [VAL_W-1:0]  b_value,
  output logic [ROW_W-1:0]  out_row,
  input  logic [HIT_AW-1:0] hr_addr,
  output logic [HIT_W-1:0]  hr_data,
  output logic [HIT_AW:0]   hr_count,
  output logic              hr_overflow
);
  localparam int VAL_DEPTH = SLOTS * CHANNELS;
  localparam int VAL_AW    = $clog2(VAL_DEPTH);
  localparam logic [CH_W-1:0]   LAST_CH   = CH_W'(CHANNELS - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  // Row buffer state
  logic [VAL_W-1:0]    thr_q;
  logic [SLOT_W-1:0]   wr_slot, rd_slot;
  logic [CH_W-1:0]     wr_ch;
  logic [ROW_W-1:0]    wr_row;
  logic [ROW_W-1:0]    slot_row [SLOTS];
  logic [CHANNELS-1:0] flags    [SLOTS];
  logic [SLOTS-1:0]    slot_full;
  logic                accept, wr_last;

  // Scanner
  logic                pa_found, pb_found;
  logic [CH_W-1:0]     pa_idx, pb_idx;
  scan_act_e           act;
  logic [VAL_AW-1:0]   wr_addr;
  logic [VAL_AW-1:0]   rd_addr [2];
  logic [VAL_W-1:0]    rd_val  [2];
  logic [HIT_W-1:0]    hit_wdata;

  assign in_ready = !slot_full[wr_slot];
  assign accept   = in_valid && in_ready;
  assign wr_last  = (wr_ch == LAST_CH);

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q     <= '1;
      wr_slot   <= '0;
      rd_slot   <= '0;
      wr_ch     <= '0;
      wr_row    <= '0;
      slot_full <= '0;
      for (int s = 0; s < SLOTS; s++) begin
        flags[s]    <= '0;
        slot_row[s] <= '0;
      end
    end else begin
      if (thr_we) thr_q <= thr_data;
      if (accept) begin
        flags[wr_slot][wr_ch] <= (in_value >= thr_q);
        if (wr_last) begin
          wr_ch              <= '0;
          slot_full[wr_slot] <= 1'b1;
          slot_row[wr_slot]  <= wr_row;
          wr_row             <= wr_row + 1'b1;
          wr_slot            <= (wr_slot == LAST_SLOT) ? '0 : wr_slot + 1'b1;
        end else begin
          wr_ch <= wr_ch + 1'b1;
        end
      end
      if (act == ACT_HITS) begin
        flags[rd_slot][pa_idx] <= 1'b0;
        if (pb_found) flags[rd_slot][pb_idx] <= 1'b0;
      end
      if (act == ACT_EOR) begin
        slot_full[rd_slot] <= 1'b0;
        rd_slot            <= (rd_slot == LAST_SLOT) ? '0 : rd_slot + 1'b1;
      end
    end
  end

  dhs_pick2 #(.N(CHANNELS), .IW(CH_W)) pick_i (
    .mask    (flags[rd_slot]),
    .a_found (pa_found),
    .a_idx   (pa_idx),
    .b_found (pb_found),
    .b_idx   (pb_idx)
  );

  always_comb begin
    if (!slot_full[rd_slot]) act = ACT_IDLE;
    else if (pa_found)       act = ACT_HITS;
    else                     act = ACT_EOR;
  end

  assign wr_addr    = VAL_AW'(wr_slot) * VAL_AW'(CHANNELS) + VAL_AW'(wr_ch);
  assign rd_addr[0] = VAL_AW'(rd_slot) * VAL_AW'(CHANNELS) + VAL_AW'(pa_idx);
  assign rd_addr[1] = VAL_AW'(rd_slot) * VAL_AW'(CHANNELS) + VAL_AW'(pb_idx);

  // One memory copy per output port, both written alike
  for (genvar p = 0; p < 2; p++) begin : g_val
    dhs_value_ram #(.W(VAL_W), .DEPTH(VAL_DEPTH), .AW(VAL_AW)) ram_i (
      .clk   (clk),
      .we    (accept),
      .waddr (wr_addr),
      .wdata (in_value),
      .raddr (rd_addr[p]),
      .rdata (rd_val[p])
    );
  end

  assign a_value = rd_val[0];
  assign b_value = rd_val[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      a_valid <= 1'b0;
      b_valid <= 1'b0;
      a_chan  <= '0;
      b_chan  <= '0;
      out_row <= '0;
    end else begin
      a_valid <= (act == ACT_HITS);
      b_valid <= (act == ACT_HITS) && pb_found;
      a_chan  <= pa_idx;
      b_chan  <= pb_idx;
      out_row <= slot_row[rd_slot];
    end
  end

  always_comb begin
    hit_wdata = '0;
    hit_wdata[HIT_W-2 -: ROW_W] = slot_row[rd_slot];
    if (act == ACT_EOR) begin
      hit_wdata[HIT_W-1] = 1'b1;
    end else begin
      hit_wdata[CH_W-1:0]        = pa_idx;
      hit_wdata[CH_W]            = pa_found;
      hit_wdata[2*CH_W:CH_W+1]   = pb_found ? pb_idx : '0;
      hit_wdata[2*CH_W+1]        = pb_found;
    end
  end

  dhs_hit_ram #(.W(HIT_W), .DEPTH(HIT_DEPTH), .AW(HIT_AW)) hit_i (
    .clk      (clk),
    .rst      (rst),
    .we       (act != ACT_IDLE),
    .wdata    (hit_wdata),
    .raddr    (hr_addr),
    .rdata    (hr_data),
    .count    (hr_count),
    .overflow (hr_overflow)
  );
endmodule

// File: rtl/dual_hit_scanner_chk.sv
module dual_hit_scanner_chk #(
  parameter int HIT_DEPTH = 64,
  parameter int CH_W      = 7,
  parameter int HIT_AW    = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              a_valid,
  input logic [CH_W-1:0]   a_chan,
  input logic              b_valid,
  input logic [CH_W-1:0]   b_chan,
  input logic [HIT_AW:0]   hr_count,
  input logic              hr_overflow
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!a_valid && !b_valid && hr_count == '0 && !hr_overflow && in_ready));

  assert_b_needs_a_R3: assert property (@(posedge clk) disable iff (rst)
    b_valid |-> a_valid);

  assert_pair_order_R3: assert property (@(posedge clk) disable iff (rst)
    (a_valid && b_valid) |-> (a_chan < b_chan));

  assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (hr_count == $past(hr_count) || hr_count == $past(hr_count) + 1'b1));

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
    hr_count <= (HIT_AW + 1)'(HIT_DEPTH));

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    hr_overflow |=> hr_overflow);

  assert_overflow_only_full_R8: assert property (@(posedge clk) disable iff (rst)
    (!hr_overflow && hr_count != (HIT_AW + 1)'(HIT_DEPTH)) |=> !hr_overflow);
endmodule

bind dual_hit_scanner dual_hit_scanner_chk #(
  .HIT_DEPTH (HIT_DEPTH),
  .CH_W      (CH_W),
  .HIT_AW    (HIT_AW)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .in_ready    (in_ready),
  .a_valid     (a_valid),
  .a_chan      (a_chan),
  .b_valid     (b_valid),
  .b_chan      (b_chan),
  .hr_count    (hr_count),
  .hr_overflow (hr_overflow)
);

// File: tb/dual_hit_scanner_tb_top.sv
module dual_hit_scanner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CH = 128;
  localparam int HD = 64;

  typedef struct packed {
    logic [7:0]  row;
    logic [6:0]  ach;
    logic [11:0] aval;
    logic        bv;
    logic [6:0]  bch;
    logic [11:0] bval;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        thr_we = 1'b0;
  logic [11:0] thr_data = '0;
  logic        in_valid = 1'b0;
  logic [11:0] in_value = '0;
  logic        in_ready;
  logic        a_valid, b_valid;
  logic [6:0]  a_chan, b_chan;
  logic [11:0] a_value, b_value;
  logic [7:0]  out_row;
  logic [5:0]  hr_addr = '0;
  logic [24:0] hr_data;
  logic [6:0]  hr_count;
  logic        hr_overflow;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  int    cur_thr = 4095;
  item_t exp_q[$];
  logic [24:0] exp_words[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_hit_scanner dut_i (
    .clk(clk), .rst(rst), .thr_we(thr_we), .thr_data(thr_data),
    .in_valid(in_valid), .in_value(in_value), .in_ready(in_ready),
    .a_valid(a_valid), .a_chan(a_chan), .a_value(a_value),
    .b_valid(b_valid), .b_chan(b_chan), .b_value(b_value),
    .out_row(out_row), .hr_addr(hr_addr), .hr_data(hr_data),
    .hr_count(hr_count), .hr_overflow(hr_overflow)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] val_of(input int kind, input int ch);
    case (kind)
      0: return (ch == 3) ? 12'd4094 : (ch == 7) ? 12'd4095 : 12'd0;
      1: return (ch == 5) ? 12'd100 : (ch == 9) ? 12'd99 :
                (ch == 20) ? 12'd300 : (ch == 127) ? 12'd4095 : 12'd0;
      3: return (ch == 0) ? 12'd101 : 12'd0;
      4: return 12'(ch);
      5: return 12'd4095;
      default: return 12'd0;
    endcase
  endfunction

  task automatic set_thr(input int t);
    @(negedge clk);
    thr_we = 1'b1; thr_data = 12'(t);
    @(negedge clk);
    thr_we = 1'b0;
    cur_thr = t;
  endtask

  // Driver: expected port items and hit records, then the row samples
  task automatic send_row(input int kind, input int rownum);
    int hits[$];
    item_t it;
    for (int ch = 0; ch < CH; ch++)
      if (int'(val_of(kind, ch)) >= cur_thr) hits.push_back(ch);
    for (int i = 0; i < hits.size(); i += 2) begin
      it.row  = 8'(rownum);
      it.ach  = 7'(hits[i]);
      it.aval = val_of(kind, hits[i]);
      it.bv   = (i + 1 < hits.size());
      it.bch  = it.bv ? 7'(hits[i+1]) : 7'd0;
      it.bval = it.bv ? val_of(kind, hits[i+1]) : 12'd0;
      exp_q.push_back(it);
      exp_words.push_back({1'b0, it.row, it.bv, it.bch, 1'b1, it.ach});
    end
    exp_words.push_back({1'b1, 8'(rownum), 16'd0});
    for (int ch = 0; ch < CH; ch++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_value = val_of(kind, ch);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (b_valid && !a_valid) check(0, "R3", "b_valid without a_valid", 1, 0);
      if (a_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R5", "unexpected port output chan", a_chan, -1);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          check(a_chan == e.ach, "R3", "a_chan", a_chan, e.ach);
          check(b_valid == e.bv, "R3", "b_valid", b_valid, e.bv);
          if (e.bv) begin
            check(b_chan == e.bch, "R3", "b_chan", b_chan, e.bch);
            check(b_value == e.bval, "R4", "b_value", b_value, e.bval);
          end
          check(a_value == e.aval, "R4", "a_value", a_value, e.aval);
          check(out_row == e.row, "R10", "out_row", out_row, e.row);
        end
      end
    end
  end

  task automatic drain(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
    check(a_valid == 1'b0, "R1", "a_valid", a_valid, 0);
    check(b_valid == 1'b0, "R1", "b_valid", b_valid, 0);
    check(hr_count == 7'd0, "R1", "hr_count", hr_count, 0);
    check(hr_overflow == 1'b0, "R1", "hr_overflow", hr_overflow, 0);
    rst = 1'b0;

    // R2: threshold at reset is all ones, only 4095 is a hit
    send_row(0, 0);
    drain(20);
    check(exp_q.size() == 0, "R2", "pending after reset-threshold row", exp_q.size(), 0);
    check(hr_count == 7'd2, "R2", "records after row 0", hr_count, 2);

    set_thr(100);
    send_row(1, 1);   // equal, below and above threshold
    send_row(2, 2);   // no hits: R5
    send_row(3, 3);   // single hit: B invalid
    set_thr(50);
    send_row(4, 4);   // ramp, 78 hits
    drain(150);
    check(exp_q.size() == 0, "R2", "pending after ramp row", exp_q.size(), 0);
    check(hr_count == 7'(exp_words.size()), "R6", "record count before fill",
          hr_count, exp_words.size());
    check(hr_overflow == 1'b0, "R8", "overflow before fill", hr_overflow, 0);

    send_row(5, 5);   // every channel hits, fills the memory
    drain(200);
    check(exp_q.size() == 0, "R8", "port items still delivered", exp_q.size(), 0);
    check(hr_count == 7'(HD), "R8", "count saturates", hr_count, HD);
    check(hr_overflow == 1'b1, "R8", "overflow set", hr_overflow, 1);

    for (int i = 0; i < HD; i++) begin
      @(negedge clk);
      hr_addr = 6'(i);
      @(negedge clk);
      if (exp_words[i][24])
        check(hr_data == exp_words[i], "R7 R9", "end-of-row record", hr_data, exp_words[i]);
      else
        check(hr_data == exp_words[i], "R6 R9", "hit record", hr_data, exp_words[i]);
    end
    check(hr_overflow == 1'b1, "R8", "overflow stays set", hr_overflow, 1);
    finish_run();
  end
endmodule